// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address. It reads a two-level page table that sits in external memory. A requester presents the logical address and an access type on a ready/valid request channel. The walker then takes the address apart into three fields: a 10-bit top-level index in bits [31:22], a 10-bit second-level index in bits [21:12], and a 12-bit byte offset that passes through untouched. The pages are 4 KiB.

The walker has one read port toward memory, with at most one read in flight. It first reads the top-level entry, which is located from a table-base setting. It then reads the second-level entry, which is located from the base held in the first entry. It returns a physical address or a fault code on a ready/valid response channel. A table-length setting bounds the top-level index. An index that fails this bound faults before any memory traffic, and each entry carries a valid flag that is checked.

Only one translation is in progress at a time. A successful walk costs two memory reads before the data access can be issued.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and both `mem_req_valid` and `rsp_valid` are 0.
- R2: The first read of a walk targets `cfg_base + 4*va[31:22]`. `cfg_base` is the value sampled when the request is accepted.
- R3: The second read targets `{E1[31:12], 12'h000} + 4*va[21:12]`, where E1 is the first entry read.
- R4: When both entries have bit 0 set, the response has fault code 0 and `rsp_paddr = {E2[31:12], va[11:0]}`. E2 is the second entry.
- R5: When `va[31:22] >= cfg_len`, the response carries fault code 1 and no memory read is issued. This includes the case `cfg_len = 0`.
- R6: When bit 0 of E1 is 0, the response carries fault code 2 after exactly one memory read.
- R7: When bit 0 of E2 is 0, the response carries fault code 3 after exactly two memory reads.
- R8: `req_ready` is 0 from the acceptance of a request until its response has been taken. This allows only one translation at a time.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, the response stays valid and its fields do not change.
- R10: While a read waits for `mem_req_ready`, `mem_req_valid` stays high and `mem_req_addr` is held. No new read is requested between a read handshake and its `mem_rsp_valid`.
- R11: `rsp_acc` returns the `req_acc` value of the request it answers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | 32 | Physical base of the top-level table |
| cfg_len | input | 11 | Number of valid top-level entries (0 to 1024) |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 32 | Logical address to translate |
| req_acc | input | 2 | Access type, returned with the response |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Entry word read |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_paddr | output | 32 | Physical address (0 on a fault) |
| rsp_fault | output | 2 | 0 none, 1 length, 2 top-level invalid, 3 second-level invalid |
| rsp_acc | output | 2 | Access type of the answered request |

## Verification
The bench runs the walk with index and offset values at both ends of their ranges. It uses an index one below the table length and an index equal to it, and a zero table length; together these place the bound exactly at the comparison. A valid top-level entry followed by an invalid second-level entry, and an invalid top-level entry on its own, show whether the walk stops at the correct step with the correct code. A read count shows whether the length fault stays off the memory port. Memory stalls, memory latency and a held-back response show that the addresses and the results stay put while the walker waits.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_LEN   = 2'd1,
        FLT_OUTER = 2'd2,
        FLT_INNER = 2'd3
    } flt_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OUT_REQ,
        ST_OUT_WAIT,
        ST_IN_REQ,
        ST_IN_WAIT,
        ST_RESP
    } walk_st_e;
endpackage

// File: rtl/ptw_va_split.sv
module ptw_va_split #(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12,
    parameter int IDX_W = 10,
    localparam int LEN_W = IDX_W + 1
) (
    input  logic [VA_W-1:0]  va,
    input  logic [LEN_W-1:0] len,
    output logic [IDX_W-1:0] outer_idx,
    output logic [IDX_W-1:0] inner_idx,
    output logic [OFF_W-1:0] offset,
    output logic             in_range
);
    assign outer_idx = va[OFF_W+IDX_W +: IDX_W];
    assign inner_idx = va[OFF_W +: IDX_W];
    assign offset    = va[OFF_W-1:0];
    // index compared one bit wider so that len = 2**IDX_W admits every index
    assign in_range  = {1'b0, outer_idx} < len;
endmodule

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
    parameter int PA_W   = 32,
    parameter int IDX_W  = 10,
    parameter int ENT_LG = 2
) (
    input  logic [PA_W-1:0]  tbase,
    input  logic [IDX_W-1:0] idx,
    output logic [PA_W-1:0]  addr
);
    assign addr = tbase + (PA_W'(idx) << ENT_LG);
endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode #(
    parameter int PTE_W     = 32,
    parameter int PA_W      = 32,
    parameter int OFF_W     = 12,
    parameter int VALID_BIT = 0,
    localparam int FRM_W    = PA_W - OFF_W
) (
    input  logic [PTE_W-1:0] pte,
    output logic             valid,
    output logic [PA_W-1:0]  base
);
    assign valid = pte[VALID_BIT];
    assign base  = {pte[OFF_W +: FRM_W], {OFF_W{1'b0}}};
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int OFF_W     = 12,
    parameter int IDX_W     = 10,
    parameter int PTE_W     = 32,
    parameter int VALID_BIT = 0,
    parameter int ACC_W     = 2,
    localparam int LEN_W    = IDX_W + 1,
    localparam int ENT_LG   = $clog2(PTE_W / 8)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PA_W-1:0]  cfg_base,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [ACC_W-1:0] req_acc,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic [1:0]       rsp_fault,
    output logic [ACC_W-1:0] rsp_acc
);
    typedef struct packed {
        walk_st_e         st;
        logic [VA_W-1:0]  va;
        logic [ACC_W-1:0] acc;
        logic [PA_W-1:0]  tbase;
        logic [PA_W-1:0]  paddr;
        flt_e             flt;
    } walk_t;

    walk_t w_d, w_q;

    logic [VA_W-1:0]  split_va;
    logic [IDX_W-1:0] outer_idx, inner_idx, ent_idx;
    logic [OFF_W-1:0] offset;
    logic             in_range;
    logic             pte_valid;
    logic [PA_W-1:0]  pte_base;

    // in idle the incoming address is split, afterwards the latched one
    assign split_va = (w_q.st == ST_IDLE) ? req_vaddr : w_q.va;
    assign ent_idx  = (w_q.st == ST_OUT_REQ) ? outer_idx : inner_idx;

    ptw_va_split #(.VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_split (
        .va(split_va), .len(cfg_len), .outer_idx(outer_idx),
        .inner_idx(inner_idx), .offset(offset), .in_range(in_range)
    );

    ptw_entry_addr #(.PA_W(PA_W), .IDX_W(IDX_W), .ENT_LG(ENT_LG)) u_eaddr (
        .tbase(w_q.tbase), .idx(ent_idx), .addr(mem_req_addr)
    );

    ptw_pte_decode #(.PTE_W(PTE_W), .PA_W(PA_W), .OFF_W(OFF_W),
                     .VALID_BIT(VALID_BIT)) u_pte (
        .pte(mem_rsp_data), .valid(pte_valid), .base(pte_base)
    );

    always_comb begin
        w_d = w_q;
        case (w_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    w_d.va    = req_vaddr;
                    w_d.acc   = req_acc;
                    w_d.tbase = cfg_base;
                    w_d.paddr = '0;
                    if (in_range) begin
                        w_d.flt = FLT_NONE;
                        w_d.st  = ST_OUT_REQ;
                    end else begin
                        w_d.flt = FLT_LEN;
                        w_d.st  = ST_RESP;
                    end
                end
            end
            ST_OUT_REQ: if (mem_req_ready) w_d.st = ST_OUT_WAIT;
            ST_OUT_WAIT: begin
                if (mem_rsp_valid) begin
                    if (pte_valid) begin
                        w_d.tbase = pte_base;
                        w_d.st    = ST_IN_REQ;
                    end else begin
                        w_d.flt = FLT_OUTER;
                        w_d.st  = ST_RESP;
                    end
                end
            end
            ST_IN_REQ: if (mem_req_ready) w_d.st = ST_IN_WAIT;
            ST_IN_WAIT: begin
                if (mem_rsp_valid) begin
                    if (pte_valid) begin
                        w_d.paddr = pte_base | PA_W'(offset);
                    end else begin
                        w_d.flt = FLT_INNER;
                    end
                    w_d.st = ST_RESP;
                end
            end
            ST_RESP: if (rsp_ready) w_d.st = ST_IDLE;
            default: w_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q.st    <= ST_IDLE;
            w_q.va    <= '0;
            w_q.acc   <= '0;
            w_q.tbase <= '0;
            w_q.paddr <= '0;
            w_q.flt   <= FLT_NONE;
        end else begin
            w_q <= w_d;
        end
    end

    assign req_ready     = (w_q.st == ST_IDLE);
    assign mem_req_valid = (w_q.st == ST_OUT_REQ) || (w_q.st == ST_IN_REQ);
    assign rsp_valid     = (w_q.st == ST_RESP);
    assign rsp_paddr     = w_q.paddr;
    assign rsp_fault     = w_q.flt;
    assign rsp_acc       = w_q.acc;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
    parameter int VA_W  = 32,
    parameter int PA_W  = 32,
    parameter int OFF_W = 12,
    parameter int IDX_W = 10,
    parameter int ACC_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PA_W-1:0]  cfg_base,
    input logic             req_valid,
    input logic             req_ready,
    input logic [VA_W-1:0]  req_vaddr,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [PA_W-1:0]  mem_req_addr,
    input logic             mem_rsp_valid,
    input logic             rsp_valid,
    input logic             rsp_ready,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic [1:0]       rsp_fault,
    input logic [ACC_W-1:0] rsp_acc
);
    logic [1:0]      rd_n;
    logic            outst;
    logic [VA_W-1:0] va_l;
    logic [PA_W-1:0] base_l;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_n   <= '0;
            outst  <= 1'b0;
            va_l   <= '0;
            base_l <= '0;
        end else begin
            if (req_valid && req_ready) begin
                rd_n   <= '0;
                va_l   <= req_vaddr;
                base_l <= cfg_base;
            end else if (mem_req_valid && mem_req_ready) begin
                rd_n <= rd_n + 2'd1;
            end
            if (mem_req_valid && mem_req_ready) outst <= 1'b1;
            else if (mem_rsp_valid)             outst <= 1'b0;
        end
    end

    p_outer_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && rd_n == 2'd0)
        |-> mem_req_addr == base_l + (PA_W'(va_l[OFF_W+IDX_W +: IDX_W]) << 2));

    p_ok_two_reads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == 2'd0) |-> rd_n == 2'd2);

    p_len_no_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == 2'd1) |-> rd_n == 2'd0);

    p_outer_one_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == 2'd2) |-> rd_n == 2'd1);

    p_inner_two_reads_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == 2'd3) |-> rd_n == 2'd2);

    p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || mem_req_valid || outst) |-> !req_ready);

    p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready)
        |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault) && $stable(rsp_acc)));

    p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    p_one_outstanding_r10: assert property (@(posedge clk) disable iff (!rst_n)
        outst |-> !mem_req_valid);
endmodule

bind ptw_walker ptw_walker_chk u_chk (.*);

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_base = 32'h0;
    logic [10:0] cfg_len = 11'd0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = 32'h0;
    logic [1:0]  req_acc = 2'd0;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = 32'h0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_fault;
    logic [1:0]  rsp_acc;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    ptw_walker u_dut (.*);

    // memory model: programmable stall before accept, latency before data
    logic [31:0] mem [logic [31:0]];
    int          stall_cfg = 0, lat_cfg = 0;
    int          stall_left = 0, lat_left = 0;
    logic        pend = 1'b0;
    logic [31:0] pend_addr = 32'h0, held_addr = 32'h0;
    logic        was_wait = 1'b0;
    int          rd_cnt = 0, addr_chg = 0, overlap = 0;
    logic [31:0] rd_addr [4];

    assign mem_req_ready = (stall_left == 0);

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && pend) overlap <= overlap + 1;
        if (mem_req_valid) begin
            if (was_wait && mem_req_addr != held_addr) addr_chg <= addr_chg + 1;
            if (stall_left != 0) begin
                stall_left <= stall_left - 1;
                was_wait   <= 1'b1;
                held_addr  <= mem_req_addr;
            end else begin
                stall_left <= stall_cfg;
                was_wait   <= 1'b0;
                pend       <= 1'b1;
                pend_addr  <= mem_req_addr;
                lat_left   <= lat_cfg;
                rd_addr[rd_cnt[1:0]] <= mem_req_addr;
                rd_cnt     <= rd_cnt + 1;
            end
        end else begin
            stall_left <= stall_cfg;
            was_wait   <= 1'b0;
        end
        if (pend) begin
            if (lat_left == 0) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= mem.exists(pend_addr) ? mem[pend_addr] : 32'h0;
                pend          <= 1'b0;
            end else begin
                lat_left <= lat_left - 1;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic xlate(input logic [31:0] va, input logic [1:0] acc,
                         input logic [1:0] exp_flt, input logic [31:0] exp_pa,
                         input int exp_reads, input logic [31:0] exp_a0,
                         input logic [31:0] exp_a1, input int hold, input string tag);
        int start, chg0, ovl0, n;
        bit busy_ok;
        logic [31:0] pa_s;
        logic [1:0]  f_s, a_s;
        @(negedge clk);
        start = rd_cnt; chg0 = addr_chg; ovl0 = overlap;
        req_vaddr = va; req_acc = acc; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        busy_ok = 1'b1;
        n = 0;
        while (!rsp_valid && n < 200) begin
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
            n++;
        end
        check(rsp_valid, tag, "response arrives", {31'b0, rsp_valid}, 32'h1);
        check(busy_ok && !req_ready, "R8", "ready low while busy",
              {31'b0, req_ready}, 32'h0);
        pa_s = rsp_paddr; f_s = rsp_fault; a_s = rsp_acc;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            check(rsp_valid && rsp_paddr == pa_s && rsp_fault == f_s && rsp_acc == a_s,
                  "R9", "response held", rsp_paddr, pa_s);
        end
        check(f_s == exp_flt, tag, "fault code", {30'b0, f_s}, {30'b0, exp_flt});
        if (exp_flt == 2'd0) check(pa_s == exp_pa, "R4", "physical address", pa_s, exp_pa);
        check(a_s == acc, "R11", "access type echo", {30'b0, a_s}, {30'b0, acc});
        check(rd_cnt - start == exp_reads, tag, "memory read count",
              32'(rd_cnt - start), 32'(exp_reads));
        if (exp_reads >= 1)
            check(rd_addr[start[1:0]] == exp_a0, "R2", "first entry address",
                  rd_addr[start[1:0]], exp_a0);
        if (exp_reads >= 2)
            check(rd_addr[2'(start + 1)] == exp_a1, "R3", "second entry address",
                  rd_addr[2'(start + 1)], exp_a1);
        check(addr_chg == chg0 && overlap == ovl0, "R10", "read port order",
              32'(addr_chg - chg0 + overlap - ovl0), 32'h0);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        check(req_ready && !rsp_valid, "R8", "idle after take",
              {31'b0, req_ready}, 32'h1);
    endtask

    task automatic t_reset;
        check(req_ready == 1'b1, "R1", "req_ready after reset", {31'b0, req_ready}, 32'h1);
        check(!mem_req_valid, "R1", "mem_req_valid after reset", {31'b0, mem_req_valid}, 32'h0);
        check(!rsp_valid, "R1", "rsp_valid after reset", {31'b0, rsp_valid}, 32'h0);
    endtask

    task automatic t_basic;
        cfg_base = 32'h0001_0000; cfg_len = 11'd16; stall_cfg = 0; lat_cfg = 0;
        mem[32'h0001_000C] = 32'h0002_0001;
        mem[32'h0002_0014] = 32'h0ABC_D001;
        xlate(32'h00C0_5ABC, 2'd1, 2'd0, 32'h0ABC_DABC, 2,
              32'h0001_000C, 32'h0002_0014, 0, "R4");
    endtask

    task automatic t_extremes_stall;
        cfg_base = 32'h0001_0000; cfg_len = 11'd1024; stall_cfg = 2; lat_cfg = 3;
        mem[32'h0001_0FFC] = 32'h0003_0001;
        mem[32'h0003_0FFC] = 32'h1234_5003;
        xlate(32'hFFFF_FFFF, 2'd2, 2'd0, 32'h1234_5FFF, 2,
              32'h0001_0FFC, 32'h0003_0FFC, 0, "R10");
        stall_cfg = 0; lat_cfg = 0;
    endtask

    task automatic t_len_bound;
        cfg_base = 32'h0001_0000; cfg_len = 11'd16;
        mem[32'h0001_003C] = 32'h0004_0001;
        mem[32'h0004_0000] = 32'h0077_7001;
        xlate(32'h03C0_0010, 2'd0, 2'd0, 32'h0077_7010, 2,
              32'h0001_003C, 32'h0004_0000, 0, "R5");
        xlate(32'h0400_0000, 2'd3, 2'd1, 32'h0, 0, 32'h0, 32'h0, 0, "R5");
        cfg_len = 11'd0;
        xlate(32'h00C0_5ABC, 2'd2, 2'd1, 32'h0, 0, 32'h0, 32'h0, 0, "R5");
        cfg_len = 11'd16;
    endtask

    task automatic t_outer_invalid;
        mem[32'h0001_001C] = 32'h0005_0000;
        xlate(32'h01C0_0123, 2'd1, 2'd2, 32'h0, 1, 32'h0001_001C, 32'h0, 0, "R6");
    endtask

    task automatic t_inner_invalid;
        mem[32'h0001_0020] = 32'h0006_0001;
        mem[32'h0006_0008] = 32'h9999_9000;
        xlate(32'h0200_2456, 2'd2, 2'd3, 32'h0, 2,
              32'h0001_0020, 32'h0006_0008, 0, "R7");
    endtask

    task automatic t_backpressure;
        lat_cfg = 1;
        xlate(32'h00C0_5ABC, 2'd3, 2'd0, 32'h0ABC_DABC, 2,
              32'h0001_000C, 32'h0002_0014, 4, "R9");
        lat_cfg = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_basic;
        t_extremes_stall;
        t_len_bound;
        t_outer_invalid;
        t_inner_invalid;
        t_backpressure;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule